// File: doc/BRIEF.md
# Time-of-Day Counter with Pulse-per-Second Capture

This block keeps wall-clock time as a 32-bit count of whole seconds plus a 30-bit nanoseconds part. It runs from one reference clock. On every cycle the nanoseconds part grows by a fixed step, set by the parameter `NS_INC`. When the nanoseconds part passes 999,999,999 it wraps, keeps the remainder, and adds one to the seconds count. Software reads the time over a byte-wide register port. Reading the lowest time byte freezes a copy of the whole 64-bit value, so the other seven bytes can be read later and still describe the same instant. Software sets the time by writing eight staging bytes. The write to the top staging byte loads the counter.

A pulse-per-second input passes through a two-flop synchroniser and an edge detector. A rising edge and a falling edge each have their own timestamp register, their own 32-bit sequence count and their own sticky "new event" flag. A control bit for each edge turns its capture on or off. Software polls the flags. Reading the low byte of an edge's sequence register clears that edge's flag.

Top module: `tod_pps_stamp`

## Requirements
- R1: After a synchronous reset, the time, both stamps, both sequence counts, both flags and the control byte (address 0x10) all read as zero.
- R2: On each clock without a load, the nanoseconds part grows by `NS_INC`. A sum of 1,000,000,000 or more wraps to the remainder and adds one to the seconds count. The seconds count wraps modulo 2^32. The nanoseconds part never holds a value above 999,999,999.
- R3: Time bytes sit at addresses 0x00–0x07 in little-endian order. Bytes 0–3 hold the nanoseconds part, with bits 31:30 reading as zero. Bytes 4–7 hold the seconds count. Read data is registered and valid in the cycle after `bus_rd`.
- R4: A read of address 0x00 returns the live low byte and latches the whole 64-bit time. Reads of 0x01–0x07 return bytes of that latched copy, however many cycles later they occur.
- R5: Writes to 0x08–0x0F fill the staging word, which uses the same layout as the time word. A write to 0x0F loads the counter at the clock edge that samples the write. A staged nanoseconds value of 1,000,000,000 or more is reduced by 1,000,000,000, and one is added to the seconds count.
- R6: If `pps_in` changes before clock edge k, the stamp register loads at edge k+2. It takes the time value held between edges k+1 and k+2.
- R7: With control bit 0 set, a rising edge stores the time at 0x18–0x1F, adds one to the sequence count at 0x20–0x23, and sets flag bit 0 (address 0x11).
- R8: With control bit 1 set, a falling edge stores the time at 0x28–0x2F, adds one to the sequence count at 0x30–0x33, and sets flag bit 1.
- R9: An edge whose control bit is clear leaves that edge's stamp, sequence count and flag unchanged.
- R10: If a capture and a load happen at the same clock edge, the stamp holds the time from before the load, and the counter takes the loaded value.
- R11: A read of 0x20 clears flag bit 0, and a read of 0x30 clears flag bit 1. If a capture for that edge happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
A table of time loads drives the counter through several cases: a plain count, a step that crosses the one-second boundary with a leftover remainder, a seconds wrap at 2^32, an out-of-range staged nanoseconds value, and a value that rolls over while its bytes are being read. Each case separates correct carry and remainder handling from a counter that wraps at the wrong point or a read that tears across bytes. The pulse tests drive rising and falling edges with each enable combination. They check the stamp against the time two cycles after the input change, which confirms the synchroniser latency. A load placed on the capture edge and a flag clear placed on the capture edge check which action takes priority in each case.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 30;
  localparam int WORD_W = 64;
  localparam int ADDR_W = 6;
  localparam int PAD_W  = WORD_W - SEC_W - NS_W;

  localparam logic [NS_W-1:0] NS_LIMIT = 30'd1_000_000_000;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tod_t;

  // address bits [5:3] select a region, bits [2:0] a byte within it
  typedef enum logic [2:0] {
    RG_TIME   = 3'd0,
    RG_STAGE  = 3'd1,
    RG_CTRL   = 3'd2,
    RG_ASTAMP = 3'd3,
    RG_ASEQ   = 3'd4,
    RG_CSTAMP = 3'd5,
    RG_CSEQ   = 3'd6,
    RG_NONE   = 3'd7
  } region_e;

  function automatic logic [WORD_W-1:0] tod_word(tod_t t);
    return {t.sec, {PAD_W{1'b0}}, t.ns};
  endfunction

  function automatic logic [7:0] pick_byte(logic [WORD_W-1:0] w, logic [2:0] idx);
    return w[{idx, 3'b000} +: 8];
  endfunction
endpackage

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned NS_INC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  tod_t load_val,
  output tod_t tod_q
);
  localparam logic [NS_W:0] INC_W   = (NS_W+1)'(NS_INC);
  localparam logic [NS_W:0] LIMIT_W = {1'b0, NS_LIMIT};

  logic [NS_W:0] sum;
  tod_t          run_next;
  tod_t          load_norm;

  always_comb begin
    sum      = {1'b0, tod_q.ns} + INC_W;
    run_next = tod_q;
    if (sum >= LIMIT_W) begin
      run_next.ns  = NS_W'(sum - LIMIT_W);
      run_next.sec = tod_q.sec + 1'b1;
    end else begin
      run_next.ns  = sum[NS_W-1:0];
    end
    load_norm = load_val;
    if (load_val.ns >= NS_LIMIT) begin
      load_norm.ns  = load_val.ns - NS_LIMIT;
      load_norm.sec = load_val.sec + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          tod_q <= '0;
    else if (load_en) tod_q <= load_norm;
    else              tod_q <= run_next;
  end

  // R2
  ns_range_chk: assert property (@(posedge clk) disable iff (rst)
    tod_q.ns < NS_LIMIT);

  // R2
  carry_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ((tod_q.sec != $past(tod_q.sec)) == (tod_q.ns < $past(tod_q.ns))));
endmodule

// File: rtl/pps_edge_detect.sv
`timescale 1ns/1ps
module pps_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_in,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic [STAGES:0]   shift_in;

  assign shift_in = {sync_q, pps_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= shift_in[STAGES-1:0];
      last_q <= shift_in[STAGES];
    end
  end

  assign rise_o =  sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] &  last_q;
endmodule

// File: rtl/edge_capture.sv
`timescale 1ns/1ps
module edge_capture
  import tod_pkg::*;
#(
  parameter int SEQ_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             en_i,
  input  tod_t             tod_i,
  input  logic             clr_i,
  output tod_t             stamp_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             flag_o
);
  logic fire;
  assign fire = evt_i & en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_o <= '0;
      seq_o   <= '0;
      flag_o  <= 1'b0;
    end else begin
      if (fire) begin
        stamp_o <= tod_i;
        seq_o   <= seq_o + 1'b1;
      end
      if (fire)       flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  // R7
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> seq_o == $past(seq_o) + 1'b1);

  // R9
  seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(seq_o) && $stable(stamp_o));

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag_o);
endmodule

// File: rtl/tod_regs.sv
`timescale 1ns/1ps
module tod_regs
  import tod_pkg::*;
#(
  parameter int SEQ_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  tod_t                  live_tod,
  input  tod_t [1:0]            stamp_i,
  input  logic [1:0][SEQ_W-1:0] seq_i,
  input  logic [1:0]            flag_i,
  output logic [1:0]            cap_en_o,
  output logic [1:0]            clr_o,
  output logic                  load_en_o,
  output tod_t                  load_val_o
);
  region_e             region;
  logic [2:0]          idx;
  logic [WORD_W-1:0]   stage_q;
  logic [1:0]          ctrl_q;
  tod_t                snap_q;
  logic [7:0]          rd_byte;
  logic                snap_take;

  assign region    = region_e'(bus_addr[5:3]);
  assign idx       = bus_addr[2:0];
  assign snap_take = bus_rd && region == RG_TIME && idx == 3'd0;

  always_comb begin
    rd_byte = 8'h00;
    case (region)
      RG_TIME:   rd_byte = (idx == 3'd0) ? pick_byte(tod_word(live_tod), 3'd0)
                                         : pick_byte(tod_word(snap_q), idx);
      RG_STAGE:  rd_byte = pick_byte(stage_q, idx);
      RG_CTRL: begin
        case (idx)
          3'd0:    rd_byte = {6'b0, ctrl_q};
          3'd1:    rd_byte = {6'b0, flag_i};
          default: rd_byte = 8'h00;
        endcase
      end
      RG_ASTAMP: rd_byte = pick_byte(tod_word(stamp_i[0]), idx);
      RG_ASEQ:   rd_byte = pick_byte(WORD_W'(seq_i[0]), idx);
      RG_CSTAMP: rd_byte = pick_byte(tod_word(stamp_i[1]), idx);
      RG_CSEQ:   rd_byte = pick_byte(WORD_W'(seq_i[1]), idx);
      default:   rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q   <= '0;
      ctrl_q    <= '0;
      snap_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_rd)    bus_rdata <= rd_byte;
      if (snap_take) snap_q    <= live_tod;
      if (bus_wr && region == RG_STAGE) stage_q[{idx, 3'b000} +: 8] <= bus_wdata;
      if (bus_wr && region == RG_CTRL && idx == 3'd0) ctrl_q <= bus_wdata[1:0];
    end
  end

  assign cap_en_o       = ctrl_q;
  assign clr_o[0]       = bus_rd && region == RG_ASEQ && idx == 3'd0;
  assign clr_o[1]       = bus_rd && region == RG_CSEQ && idx == 3'd0;
  assign load_en_o      = bus_wr && region == RG_STAGE && idx == 3'd7;
  assign load_val_o.sec = {bus_wdata, stage_q[55:32]};
  assign load_val_o.ns  = stage_q[NS_W-1:0];

  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !snap_take |=> $stable(snap_q));
endmodule

// File: rtl/tod_pps_stamp.sv
`timescale 1ns/1ps
module tod_pps_stamp
  import tod_pkg::*;
#(
  parameter int unsigned NS_INC      = 10,
  parameter int          SYNC_STAGES = 2,
  parameter int          SEQ_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pps_in,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  tod_t                  tod_now;
  tod_t                  load_val;
  logic                  load_en;
  logic                  rise, fall;
  logic [1:0]            evt;
  logic [1:0]            cap_en, clr;
  tod_t [1:0]            stamp;
  logic [1:0][SEQ_W-1:0] seq;
  logic [1:0]            flag;

  tod_counter #(.NS_INC(NS_INC)) u_counter (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val), .tod_q(tod_now)
  );

  pps_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pps_in(pps_in), .rise_o(rise), .fall_o(fall)
  );

  assign evt = {fall, rise};

  for (genvar e = 0; e < 2; e++) begin : g_cap
    edge_capture #(.SEQ_W(SEQ_W)) u_cap (
      .clk(clk), .rst(rst), .evt_i(evt[e]), .en_i(cap_en[e]), .tod_i(tod_now),
      .clr_i(clr[e]), .stamp_o(stamp[e]), .seq_o(seq[e]), .flag_o(flag[e])
    );
  end

  tod_regs #(.SEQ_W(SEQ_W)) u_regs (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .live_tod(tod_now),
    .stamp_i(stamp), .seq_i(seq), .flag_i(flag), .cap_en_o(cap_en),
    .clr_o(clr), .load_en_o(load_en), .load_val_o(load_val)
  );
endmodule

// File: tb/tod_pps_stamp_bench.sv
`timescale 1ns/1ps
module tod_pps_stamp_bench;
  localparam logic [30:0] INC = 31'd10;
  localparam logic [29:0] LIM = 30'd1_000_000_000;

  // {sec[32], ns[32], wait[8], exp_sec[32], exp_ns[32]}
  localparam logic [135:0] VEC [7] = '{
    {32'd0,          32'd0,          8'd0, 32'd0,          32'd0},
    {32'd5,          32'd100,        8'd3, 32'd5,          32'd130},
    {32'd7,          32'd999999995,  8'd1, 32'd8,          32'd5},
    {32'hFFFFFFFF,   32'd999999990,  8'd2, 32'd0,          32'd10},
    {32'd100,        32'd1000000500, 8'd0, 32'd101,        32'd500},
    {32'h12345678,   32'd999999999,  8'd1, 32'h12345679,   32'd9},
    {32'd9,          32'd999999960,  8'd0, 32'd9,          32'd999999960}
  };

  logic       clk = 1'b0, rst = 1'b1, pps = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int total = 0, bad = 0;

  logic [61:0] m_t;
  logic [63:0] m_stage;

  always #2 clk = ~clk;

  tod_pps_stamp u_tod_pps_stamp (
    .clk(clk), .rst(rst), .pps_in(pps), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  function automatic logic [61:0] adv(logic [61:0] t);
    logic [30:0] s = {1'b0, t[29:0]} + INC;
    if (s >= {1'b0, LIM}) return {t[61:30] + 32'd1, 30'(s - {1'b0, LIM})};
    return {t[61:30], s[29:0]};
  endfunction

  function automatic logic [61:0] norm(logic [31:0] s, logic [29:0] n);
    if (n >= LIM) return {s + 32'd1, n - LIM};
    return {s, n};
  endfunction

  function automatic logic [63:0] word(logic [61:0] t);
    return {t[61:30], 2'b00, t[29:0]};
  endfunction

  // independent time model built from R2/R5
  always @(posedge clk) begin
    if (rst) begin
      m_t <= '0;
      m_stage <= '0;
    end else begin
      if (wr && addr[5:3] == 3'd1) m_stage[{addr[2:0], 3'b000} +: 8] <= wdata;
      if (wr && addr == 6'h0F) m_t <= norm({wdata, m_stage[55:32]}, m_stage[29:0]);
      else                      m_t <= adv(m_t);
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [5:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic read64(logic [5:0] base, output logic [63:0] v);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      bus_read(base + 6'(i), b);
      v[8*i +: 8] = b;
      tick(1);
    end
  endtask

  task automatic load_time(logic [31:0] s, logic [29:0] n);
    logic [63:0] w = {s, 2'b00, n};
    for (int i = 0; i < 8; i++) bus_write(6'(8 + i), w[8*i +: 8]);
  endtask

  task automatic pps_drive(logic v, output logic [63:0] exp);
    pps = v;
    tick(2);
    exp = word(m_t);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v, e, e2, keep;
    logic [7:0]  b;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 / R3: time starts at zero right after reset
    read64(6'h00, v);   check("R1 time after reset", v, 64'd0);
    bus_read(6'h10, b); check("R1 ctrl", 64'(b), 64'd0);
    bus_read(6'h11, b); check("R1 flags", 64'(b), 64'd0);
    read64(6'h18, v);   check("R1 assert stamp", v, 64'd0);
    read64(6'h20, v);   check("R1 assert seq", v, 64'd0);
    read64(6'h28, v);   check("R1 clear stamp", v, 64'd0);
    read64(6'h30, v);   check("R1 clear seq", v, 64'd0);

    // table: R2 rollover, R3 layout, R4 snapshot, R5 load
    for (int r = 0; r < 7; r++) begin
      load_time(VEC[r][135:104], VEC[r][101:72]);
      tick(int'(VEC[r][71:64]));
      read64(6'h00, v);
      check($sformatf("R2 R3 R4 R5 row %0d", r), v, {VEC[r][63:32], VEC[r][31:0]});
    end

    // R4: long gap between byte 0 and the rest
    e = word(m_t);
    bus_read(6'h00, b); v[7:0] = b;
    tick(40);
    for (int i = 1; i < 8; i++) begin bus_read(6'(i), b); v[8*i +: 8] = b; end
    check("R4 snapshot over gap", v, e);

    // R6 R7: rising edge capture
    bus_write(6'h10, 8'h03);
    load_time(32'd50, 30'd0);
    pps_drive(1'b1, e); tick(3);
    bus_read(6'h11, b); check("R7 flag set", 64'(b), 64'd1);
    read64(6'h18, v);   check("R6 R7 assert stamp", v, e);
    read64(6'h20, v);   check("R7 assert seq", v, 64'd1);
    bus_read(6'h11, b); check("R11 flag cleared", 64'(b), 64'd0);

    // R8: falling edge capture
    pps_drive(1'b0, e); tick(3);
    bus_read(6'h11, b); check("R8 flag set", 64'(b), 64'd2);
    read64(6'h28, v);   check("R6 R8 clear stamp", v, e);
    keep = v;
    read64(6'h30, v);   check("R8 clear seq", v, 64'd1);
    bus_read(6'h11, b); check("R11 flags cleared", 64'(b), 64'd0);

    // R9: only rising enabled
    bus_write(6'h10, 8'h01);
    pps_drive(1'b1, e);  tick(3);
    pps_drive(1'b0, e2); tick(3);
    bus_read(6'h11, b); check("R9 no clear flag", 64'(b), 64'd1);
    read64(6'h30, v);   check("R9 clear seq held", v, 64'd1);
    read64(6'h28, v);   check("R9 clear stamp held", v, keep);
    read64(6'h20, v);   check("R7 assert seq two", v, 64'd2);
    read64(6'h18, keep);

    // R9: only falling enabled
    bus_write(6'h10, 8'h02);
    pps_drive(1'b1, e);  tick(3);
    pps_drive(1'b0, e2); tick(3);
    read64(6'h20, v);   check("R9 assert seq held", v, 64'd2);
    read64(6'h18, v);   check("R9 assert stamp held", v, keep);
    read64(6'h28, v);   check("R8 clear stamp", v, e2);
    read64(6'h30, v);   check("R8 clear seq two", v, 64'd2);

    // R10: load commits on the capture edge
    bus_write(6'h10, 8'h03);
    keep = {32'd700, 2'b00, 30'd123};
    for (int i = 0; i < 7; i++) bus_write(6'(8 + i), keep[8*i +: 8]);
    pps_drive(1'b1, e);
    bus_write(6'h0F, keep[63:56]);
    tick(2);
    read64(6'h18, v);   check("R10 stamp pre-load", v, e);
    e2 = word(m_t);
    read64(6'h00, v);   check("R10 load applied", v, e2);
    check("R10 seconds loaded", 64'(v[63:32]), 64'd700);

    // R11: capture wins over clear in the same cycle
    read64(6'h20, v);
    read64(6'h30, v);
    bus_read(6'h11, b); check("R11 both clear", 64'(b), 64'd0);
    pps_drive(1'b0, e);
    bus_read(6'h30, b);
    tick(1);
    bus_read(6'h11, b); check("R11 set wins", 64'(b), 64'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule